// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host side of a three-wire link to a 12-bit successive-approximation converter. The link has an active-low select, a data clock that the host drives, and one serial data line back from the converter. A request on `start` lowers the select. The data clock is then generated from the system clock through a programmable half-period divider. The controller lets the converter's two sampling periods and its leading zero slot pass, then collects the conversion bits most significant first. When the read is finished it raises the select, which puts the converter into its lowest-power state. It holds the select high for one full data-clock period and then reports the result with a one-cycle `done` pulse.

A read can be cut short to the top n bits. This trades resolution for a shorter frame and more time powered down. The partial word is left-aligned and its unread low bits are zero. A verify mode always reads the whole word and then keeps clocking while the converter replays the word least significant bit first. The controller compares the eleven replayed bits with the word already captured and flags any disagreement.

Top module: `sadc_reader`

## Requirements
- R1: After reset and between reads: `adc_cs_n` is 1, `adc_sclk` is 0, `done` is 0, and `result`, `nbits` and `mismatch` are 0 until the first read completes.
- R2: While select is low, each data-clock phase (high or low) lasts exactly `half_div` system cycles. A value of 0 is treated as 1.
- R3: When select falls, the data clock is low. The first rising data-clock edge comes exactly `half_div` system cycles later.
- R4: Data is sampled on rising data-clock edges. Rising edges 1 and 2 belong to sampling and rising edge 3 carries the leading zero; all three are discarded. Rising edges 4, 5, … carry result bits 11, 10, … in turn. A normal read makes exactly 3+n rising edges with select low.
- R5: The read length n is `rd_len` when it is 1 to 12, and 12 when `rd_len` is 0 or above 12. `result` holds the n bits in bits 11 down to 12−n, with lower bits 0, and `nbits` equals n.
- R6: With `verify_en` set at start, n is 12 whatever `rd_len` holds, and 26 rising edges are made. The bits sampled on rising edges 16 to 26 are compared with result bits 1 to 11 in that order. `mismatch` is 1 exactly when any of them differs.
- R7: Select rises on the falling data-clock edge that ends the last sampled bit. `done` follows exactly 2·`half_div` system cycles later, with the data clock held low throughout.
- R8: `done` is high for one system cycle per read. `result`, `nbits` and `mismatch` change only with `done` and hold until the next `done`.
- R9: A `start` pulse while a read is under way has no effect: the frame length and result are unchanged, and no extra read follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle read request, taken only when idle |
| half_div | input | DIV_W | Data-clock half period in system cycles (0 acts as 1) |
| rd_len | input | 4 | Requested number of bits; 0 or above 12 means 12 |
| verify_en | input | 1 | Full read plus replay comparison |
| adc_miso | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Data clock to the converter |
| done | output | 1 | One-cycle pulse when a result is ready |
| result | output | 12 | Left-aligned conversion word |
| nbits | output | 4 | Number of valid bits in `result` |
| mismatch | output | 1 | Replay disagreed with the captured word |

## Verification
The assertions assume that `half_div` and `rd_len` stay constant while a read runs. The bench only changes them at idle, before each `start`. They also assume `adc_miso` changes only after falling data-clock edges while select is low. The bench's converter model meets this: it updates the line only on those edges, drives zero whenever select is high, and can flip one chosen replay bit. Random frames draw the divider from 0 to 3, every `rd_len` code and verify mode. Directed frames add single-bit reads, the out-of-range length codes, a corrupted top replay bit and a request issued mid-frame.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int unsigned DATA_W       = 12;
    localparam int unsigned LEAD_RISES   = 3;
    localparam int unsigned LEN_W        = $clog2(DATA_W + 1);
    localparam int unsigned FULL_RISES   = LEAD_RISES + DATA_W;
    localparam int unsigned VERIFY_RISES = FULL_RISES + DATA_W - 1;
    localparam int unsigned RC_W         = $clog2(VERIFY_RISES + 1);
    localparam int unsigned BIDX_W       = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_TAIL,
        ST_REST
    } seq_state_e;

    typedef struct packed {
        logic             verify;
        logic [LEN_W-1:0] n;
    } frame_cfg_t;

    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] req,
                                                  input logic verify);
        if (verify || req == '0 || req > LEN_W'(DATA_W))
            return LEN_W'(DATA_W);
        return req;
    endfunction

    function automatic logic [DATA_W-1:0] low_mask(input logic [LEN_W-1:0] n);
        return {DATA_W{1'b1}} >> n;
    endfunction

endpackage

// File: rtl/sadc_clkgen.sv
module sadc_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk_q,
    output logic             rise_now,
    output logic             fall_now
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] hd;
    logic             tick;

    always_comb begin
        hd       = (half_div == '0) ? DIV_W'(1) : half_div;
        tick     = run && (cnt == hd - DIV_W'(1));
        rise_now = tick && !sclk_q;
        fall_now = tick && sclk_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt    <= cnt + DIV_W'(1);
        end
    end

    // R2: with a divider above one, a phase never lasts a single cycle
    p_min_phase_r2: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (sclk_q != $past(sclk_q)) && hd > DIV_W'(1))
        |=> (!run || $stable(sclk_q)));

    // R1: the clock is parked low whenever it is not running
    p_park_low_r1: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sclk_q);

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  rd_len,
    input  logic              verify_in,
    input  logic              rise_now,
    input  logic              fall_now,
    input  logic              miso,
    output logic              clk_run,
    output logic              cs_active,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [LEN_W-1:0]  nbits,
    output logic              mismatch
);

    seq_state_e         st;
    frame_cfg_t         cfg;
    logic [RC_W-1:0]    rcnt;
    logic [RC_W-1:0]    k;
    logic [RC_W-1:0]    last;
    logic [DATA_W-1:0]  word;
    logic [DATA_W-2:0]  rep;
    logic [BIDX_W-1:0]  bit_idx;
    logic               in_word;
    logic               in_replay;

    always_comb begin
        k         = rcnt + RC_W'(1);
        last      = cfg.verify ? RC_W'(VERIFY_RISES)
                               : RC_W'(LEAD_RISES) + RC_W'(cfg.n);
        in_word   = (k > RC_W'(LEAD_RISES)) && (k <= RC_W'(FULL_RISES));
        in_replay = (k > RC_W'(FULL_RISES));
        bit_idx   = BIDX_W'(RC_W'(FULL_RISES) - k);
        clk_run   = (st != ST_IDLE);
        cs_active = (st == ST_RUN) || (st == ST_TAIL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cfg      <= '0;
            rcnt     <= '0;
            word     <= '0;
            rep      <= '0;
            done     <= 1'b0;
            result   <= '0;
            nbits    <= '0;
            mismatch <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        cfg.verify <= verify_in;
                        cfg.n      <= eff_len(rd_len, verify_in);
                        rcnt       <= '0;
                        word       <= '0;
                        rep        <= '0;
                        st         <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (rise_now) begin
                        rcnt <= k;
                        if (in_word)
                            word[bit_idx] <= miso;
                        else if (in_replay)
                            rep <= {miso, rep[DATA_W-2:1]};
                        if (k == last)
                            st <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (fall_now)
                        st <= ST_REST;
                end
                ST_REST: begin
                    if (fall_now) begin
                        st       <= ST_IDLE;
                        done     <= 1'b1;
                        result   <= word;
                        nbits    <= cfg.n;
                        mismatch <= cfg.verify && (rep != word[DATA_W-1:1]);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9: the latched frame setup cannot change while a read is under way
    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(cfg));

    // R5: the active length always lies in 1..DATA_W
    p_len_range_r5: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |-> (cfg.n >= LEN_W'(1) && cfg.n <= LEN_W'(DATA_W)));

    // R4: the rising-edge count never passes the frame end
    p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> (rcnt < last));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
    import sadc_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [LEN_W-1:0]  rd_len,
    input  logic              verify_en,
    input  logic              adc_miso,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [LEN_W-1:0]  nbits,
    output logic              mismatch
);

    logic clk_run;
    logic cs_active;
    logic sclk_q;
    logic rise_now;
    logic fall_now;

    sadc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (clk_run),
        .half_div (half_div),
        .sclk_q   (sclk_q),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    sadc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rd_len    (rd_len),
        .verify_in (verify_en),
        .rise_now  (rise_now),
        .fall_now  (fall_now),
        .miso      (adc_miso),
        .clk_run   (clk_run),
        .cs_active (cs_active),
        .done      (done),
        .result    (result),
        .nbits     (nbits),
        .mismatch  (mismatch)
    );

    assign adc_cs_n = !cs_active;
    assign adc_sclk = sclk_q && cs_active;

    // R1: with select high the data clock stays low
    p_quiet_link_r1: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> !adc_sclk);

    // R5: bits below the valid count are zero in every reported word
    p_left_align_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> ((result & low_mask(nbits)) == '0));

    // R6: a reported mismatch only comes from a full-length read
    p_verify_full_r6: assert property (@(posedge clk) disable iff (rst)
        (done && mismatch) |-> (nbits == LEN_W'(DATA_W)));

    // R7: select is high while the completion pulse is issued
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> adc_cs_n);

endmodule

// File: tb/sadc_reader_bench.sv
module sadc_reader_bench;
    import sadc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  half_div = 8'd1;
    logic [3:0]  rd_len = 4'd12;
    logic        verify_en = 1'b0;
    logic        adc_miso = 1'b0;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic        done;
    logic [11:0] result;
    logic [3:0]  nbits;
    logic        mismatch;

    sadc_reader #(.DIV_W(8)) u_sadc_reader (
        .clk(clk), .rst(rst), .start(start), .half_div(half_div),
        .rd_len(rd_len), .verify_en(verify_en), .adc_miso(adc_miso),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .done(done),
        .result(result), .nbits(nbits), .mismatch(mismatch)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter model: updates data after falling data-clock edges
    logic [11:0] smp = '0;
    int          corrupt = 0;
    int          fc = 0;
    logic        last_cs = 1'b1;

    always @(negedge adc_sclk or negedge adc_cs_n or posedge adc_cs_n) begin
        if (adc_cs_n) begin
            fc = 0;
            adc_miso = 1'b0;
        end else if (last_cs) begin
            fc = 0;
            adc_miso = 1'b0;
        end else if (!adc_sclk) begin
            fc++;
            if (fc >= 3 && fc <= 14)
                adc_miso = smp[14 - fc];
            else if (fc >= 15 && fc <= 25)
                adc_miso = smp[fc - 14] ^ (corrupt == fc - 14);
            else
                adc_miso = 1'b0;
        end
        last_cs = adc_cs_n;
    end

    // link monitor, sampled away from the active edge
    int   hd_eff = 1;
    int   ph = 0, gap = 0, rises = 0, perr = 0, dones = 0, dbl = 0, cyc = 0;
    int   s_rises = 0, s_gap = 0, s_perr = 0;
    logic p_sclk = 1'b0, p_cs = 1'b1, p_done = 1'b0;

    always @(negedge clk) begin
        cyc++;
        ph++;
        gap++;
        if (p_cs && !adc_cs_n) begin
            ph = 0; rises = 0; perr = 0;
            if (adc_sclk) perr++;
        end else if (!p_cs && adc_sclk != p_sclk) begin
            if (ph != hd_eff) perr++;
            ph = 0;
            if (adc_sclk) rises++;
        end
        if (!p_cs && adc_cs_n) gap = 0;
        if (done) begin
            dones++;
            if (p_done) dbl++;
            s_rises = rises; s_gap = gap; s_perr = perr;
        end
        p_sclk = adc_sclk; p_cs = adc_cs_n; p_done = done;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int exp_n(input int rdl, input bit ver);
        if (ver || rdl == 0 || rdl > 12) return 12;
        return rdl;
    endfunction

    function automatic logic [11:0] exp_word(input logic [11:0] s, input int n);
        return s & ~(12'hFFF >> n);
    endfunction

    task automatic run_frame(input logic [11:0] s, input int rdl, input bit ver,
                             input int cor, input int hd, input bit poke);
        int n, t, d0;
        logic [11:0] r_hold;
        @(negedge clk);
        smp = s; corrupt = cor;
        half_div = 8'(hd); rd_len = 4'(rdl); verify_en = ver;
        hd_eff = (hd == 0) ? 1 : hd;
        d0 = dones;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4 * hd_eff + 2) @(negedge clk);
            start = 1'b1; rd_len = 4'd3; verify_en = 1'b0;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 4000) begin @(negedge clk); t++; end
        #1;
        n = exp_n(rdl, ver);
        chk(done, "R8 done seen", int'(done), 1);
        chk(result == exp_word(s, n), "R5 result", int'(result), int'(exp_word(s, n)));
        chk(nbits == 4'(n), "R5 nbits", int'(nbits), n);
        chk(s_rises == (ver ? 26 : 3 + n), "R4 rising edges", s_rises, ver ? 26 : 3 + n);
        chk(mismatch == (cor != 0), "R6 mismatch", int'(mismatch), int'(cor != 0));
        chk(s_perr == 0, "R2 R3 phase timing", s_perr, 0);
        chk(s_gap == 2 * hd_eff, "R7 select-high gap", s_gap, 2 * hd_eff);
        r_hold = result;
        repeat (2 * hd_eff + 6) @(negedge clk);
        #1;
        chk(result == r_hold, "R8 result held", int'(result), int'(r_hold));
        chk(dones == d0 + 1, "R9 single done", dones - d0, 1);
        chk(adc_cs_n && !adc_sclk, "R1 idle link", int'({adc_cs_n, adc_sclk}), 2);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A17));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1 cs after reset", int'(adc_cs_n), 1);
        chk(adc_sclk == 1'b0, "R1 sclk after reset", int'(adc_sclk), 0);
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        chk(result == '0 && nbits == '0 && mismatch == 1'b0, "R1 outputs after reset",
            int'({mismatch, nbits, result}), 0);

        // directed corners
        run_frame(12'hA5C, 3, 1'b0, 0, 2, 1'b0);   // R5 short read
        run_frame(12'hFFF, 12, 1'b0, 0, 1, 1'b0);  // R4 full read
        run_frame(12'h800, 0, 1'b0, 0, 3, 1'b0);   // R5 zero code means full
        run_frame(12'h7FF, 15, 1'b0, 0, 2, 1'b0);  // R5 oversize code means full
        run_frame(12'h123, 1, 1'b0, 0, 0, 1'b0);   // R2 divider 0 acts as 1
        run_frame(12'hABC, 12, 1'b1, 0, 2, 1'b0);  // R6 clean replay
        run_frame(12'hABC, 4, 1'b1, 11, 1, 1'b0);  // R6 corrupted top replay bit
        run_frame(12'h001, 5, 1'b1, 1, 2, 1'b0);   // R6 corrupted first replay bit
        run_frame(12'h5A5, 6, 1'b0, 0, 2, 1'b1);   // R9 start while busy

        for (int i = 0; i < 40; i++) begin
            bit   v;
            int   c;
            v = ($urandom % 4) == 0;
            c = (v && ($urandom % 2)) ? 1 + int'($urandom % 11) : 0;
            run_frame(12'($urandom), int'($urandom % 16), v, c, int'($urandom % 4),
                      ($urandom % 8) == 0);
        end

        chk(dbl == 0, "R8 done width", dbl, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule